// File: doc/BRIEF.md
# Split-Mode Serial Access Register

This block is a 512-entry, 4-bit-wide shift buffer placed between a row-organized memory array and a serial stream port. A whole row of the array arrives on a 2048-bit parallel bus and is captured into the buffer in one cycle. The buffer can also present its whole contents back to the array for a row write in one cycle. Between transfers, a serial pointer walks the buffer one entry per serial strobe. Depending on the direction setting, each strobe either presents the current entry on the serial output or captures the serial input into it.

In split mode the buffer acts as two 256-entry halves. The serial pointer streams through one half while the other half is refilled from the array by a half transfer. When the pointer leaves the last entry of its half, it jumps to the start tap held for the other half, so the stream has no gap. A flag output tells which half is being streamed. In non-split mode the buffer is one ring of 512 entries.

The serial strobe is a clock enable on the block clock. A single clock drives the buffer, the pointer and the transfer logic.

Top module: `split_serial_reg`

## Requirements
- R1: After a synchronous active-low reset, ser_ptr is 0, half_flag is 0, xfer_err is 0 and every entry holds 0.
- R2: A cycle with xfer_rd high loads every entry i from row_rd_data bits [4i+3:4i] and sets ser_ptr to tap_addr on the next cycle. In that cycle ser_step has no effect.
- R3: In a cycle with xfer_wr high, row_wr_en is high in the same cycle and row_wr_data bits [4i+3:4i] equal entry i.
- R4: ser_dout always shows the entry at ser_ptr. With ser_dir=0 (output), a ser_step advances the pointer and changes no entry. With ser_dir=1 (input), a ser_step writes ser_din into the entry at ser_ptr and then advances the pointer.
- R5: With split_mode=0, a step from position 511 goes to position 0, and half_flag stays 0.
- R6: With split_mode=1, half_flag is 0 while the pointer is in entries 0..255 and 1 while it is in entries 256..511. It changes only on the edge that moves the pointer into the other half, or on a full row load.
- R7: With split_mode=1, a step from the last entry of a half (ser_ptr[7:0]=255) moves the pointer into the other half. It lands at the 8-bit offset latched for that half by its most recent accepted half transfer. This includes a half transfer accepted in the same cycle.
- R8: If no half transfer has been accepted for a half since reset, the pointer enters that half at its first entry (offset 0).
- R9: With split_mode=1, split_req with split_half naming the half that is not being streamed (0 = entries 0..255, 1 = entries 256..511) loads only that half's 256 entries from the matching row_rd_data bits and latches tap_addr[7:0] as its offset. The streamed half is unchanged.
- R10: A split_req naming the half being streamed, or any split_req with split_mode=0, changes no entry, offset or pointer, and drives xfer_err high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| split_mode | input | 1 | 1 = two-half operation, 0 = single 512-entry ring |
| ser_dir | input | 1 | 0 = serial output, 1 = serial input |
| ser_step | input | 1 | Serial strobe, one entry per cycle it is high |
| ser_din | input | 4 | Serial input data |
| ser_dout | output | 4 | Entry at the serial pointer |
| ser_ptr | output | 9 | Current serial pointer |
| half_flag | output | 1 | Half being streamed in split mode (0 low, 1 high) |
| xfer_rd | input | 1 | Full row load into the buffer |
| xfer_wr | input | 1 | Full buffer write-back request |
| split_req | input | 1 | Half transfer request |
| split_half | input | 1 | Half targeted by split_req |
| tap_addr | input | 9 | Start position for a full load, offset (low 8 bits) for a half load |
| row_rd_data | input | 2048 | Row data from the array |
| row_wr_data | output | 2048 | Buffer contents toward the array |
| row_wr_en | output | 1 | Write-back strobe toward the array |
| xfer_err | output | 1 | One-cycle pulse after a rejected half transfer |

## Verification
The assertions assume the control inputs are sampled clean on the clock edge. They also assume the half boundary and wrap checks see no full row load in the same cycle, so those properties exclude xfer_rd in their antecedents. The bench drives every input only at falling edges. It issues full loads on their own, and in a separate case it deliberately overlaps a full load with a serial strobe and a half transfer with a boundary crossing. A behavioural model with plain arrays predicts the pointer, flag, serial output and error pulse on every cycle, including the row image at each write-back.

// File: rtl/sar_pkg.sv
// Package for the split-mode serial access register.
// Holds the serial direction encoding and the half-select encoding that the
// pointer and storage modules share. Assumes nothing beyond IEEE 1800-2017.
package sar_pkg;

    // Direction of the serial port
    typedef enum logic {
        SER_OUT = 1'b0,
        SER_IN  = 1'b1
    } ser_dir_e;

    // Half of the buffer (meaningful in split mode)
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

endpackage

// File: rtl/sar_store.sv
// Storage array of the serial access register.
// Keeps DEPTH entries of WIDTH bits. Priority order: full row load, then
// half row load of the selected half, then a serial write at idx.
// Assumes DEPTH is a power of two and even.
module sar_store #(
    parameter  int DEPTH = 512,
    parameter  int WIDTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int RW    = DEPTH * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_ld,
    input  logic             half_ld,
    input  logic             half_sel,
    input  logic [RW-1:0]    row_in,
    input  logic             wr_en,
    input  logic [AW-1:0]    idx,
    input  logic [WIDTH-1:0] wr_dat,
    output logic [WIDTH-1:0] rd_dat,
    output logic [RW-1:0]    row_out
);

    localparam int HALF = DEPTH / 2;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic IN_HI = (i >= HALF);
        logic [WIDTH-1:0] q;

        // Update one entry from the row bus or the serial port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (full_ld) begin
                q <= row_in[i*WIDTH +: WIDTH];
            end else if (half_ld && (half_sel == IN_HI)) begin
                q <= row_in[i*WIDTH +: WIDTH];
            end else if (wr_en && (idx == AW'(i))) begin
                q <= wr_dat;
            end
        end

        assign row_out[i*WIDTH +: WIDTH] = q;
    end

    // Serial read mux at the pointer
    assign rd_dat = row_out[idx*WIDTH +: WIDTH];

endmodule

// File: rtl/sar_ptr.sv
// Serial pointer and half-offset control.
// Advances the pointer on each step. In split mode the last entry of a half
// hands over to the other half at that half's latched offset. Also judges
// half transfer requests and pulses an error for rejected ones.
// Assumes DEPTH is a power of two so the ring wraps by overflow.
module sar_ptr #(
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int HW    = AW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          split_mode,
    input  logic          full_ld,
    input  logic          step,
    input  logic          split_req,
    input  logic          split_half,
    input  logic [AW-1:0] tap,
    output logic [AW-1:0] ptr,
    output logic          half_flag,
    output logic          split_ok,
    output logic          err
);

    import sar_pkg::*;

    logic [AW-1:0] ptr_q, ptr_d;
    logic [HW-1:0] off_lo_q, off_hi_q;
    logic [HW-1:0] entry_off;
    logic          active;
    logic          at_end;
    logic          err_q;

    assign active   = ptr_q[AW-1];
    assign at_end   = &ptr_q[HW-1:0];
    assign split_ok = split_req && split_mode && (split_half != active);

    // Offset of the half about to be entered, honouring a same-cycle load
    always_comb begin
        if (active == HALF_HI) begin
            entry_off = (split_ok && split_half == HALF_LO) ? tap[HW-1:0] : off_lo_q;
        end else begin
            entry_off = (split_ok && split_half == HALF_HI) ? tap[HW-1:0] : off_hi_q;
        end
    end

    // Next pointer: full load first, then stepping
    always_comb begin
        ptr_d = ptr_q;
        if (full_ld) begin
            ptr_d = tap;
        end else if (step) begin
            if (split_mode && at_end) begin
                ptr_d = {~active, entry_off};
            end else begin
                ptr_d = ptr_q + AW'(1);
            end
        end
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // Per-half offsets latched by accepted half transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_lo_q <= '0;
            off_hi_q <= '0;
        end else if (split_ok) begin
            if (split_half == HALF_HI) off_hi_q <= tap[HW-1:0];
            else                       off_lo_q <= tap[HW-1:0];
        end
    end

    // One-cycle error pulse for a rejected half transfer
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= split_req && !split_ok;
    end

    assign ptr       = ptr_q;
    assign half_flag = split_mode && ptr_q[AW-1];
    assign err       = err_q;

endmodule

// File: rtl/split_serial_reg.sv
// Split-mode serial access register, top level.
// Joins the storage array and the pointer control, and gates serial writes
// by direction and by full row loads. The serial strobe is a clock enable
// on clk. Assumes DEPTH is a power of two.
module split_serial_reg #(
    parameter  int DEPTH = 512,
    parameter  int WIDTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int RW    = DEPTH * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_mode,
    input  logic             ser_dir,
    input  logic             ser_step,
    input  logic [WIDTH-1:0] ser_din,
    output logic [WIDTH-1:0] ser_dout,
    output logic [AW-1:0]    ser_ptr,
    output logic             half_flag,
    input  logic             xfer_rd,
    input  logic             xfer_wr,
    input  logic             split_req,
    input  logic             split_half,
    input  logic [AW-1:0]    tap_addr,
    input  logic [RW-1:0]    row_rd_data,
    output logic [RW-1:0]    row_wr_data,
    output logic             row_wr_en,
    output logic             xfer_err
);

    import sar_pkg::*;

    logic          half_ok;
    logic          ser_wr;
    logic [AW-1:0] ptr_w;

    // Serial write only in input mode and never under a full load
    assign ser_wr = ser_step && (ser_dir == SER_IN) && !xfer_rd;

    sar_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .split_mode (split_mode),
        .full_ld    (xfer_rd),
        .step       (ser_step),
        .split_req  (split_req),
        .split_half (split_half),
        .tap        (tap_addr),
        .ptr        (ptr_w),
        .half_flag  (half_flag),
        .split_ok   (half_ok),
        .err        (xfer_err)
    );

    sar_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_ld  (xfer_rd),
        .half_ld  (half_ok),
        .half_sel (split_half),
        .row_in   (row_rd_data),
        .wr_en    (ser_wr),
        .idx      (ptr_w),
        .wr_dat   (ser_din),
        .rd_dat   (ser_dout),
        .row_out  (row_wr_data)
    );

    assign ser_ptr   = ptr_w;
    assign row_wr_en = xfer_wr;

endmodule

// File: rtl/sar_chk.sv
// Property checker for split_serial_reg, attached by bind.
// Watches pointer, flag and error behaviour at the ports.
module sar_chk #(
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int HW    = AW - 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          split_mode,
    input logic          ser_step,
    input logic          xfer_rd,
    input logic          split_req,
    input logic          half_flag,
    input logic          xfer_err,
    input logic [AW-1:0] ser_ptr,
    input logic [AW-1:0] tap_addr
);

    // R2
    xfer_rd_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rd |=> ser_ptr == $past(tap_addr));

    // R5
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_mode && ser_step && !xfer_rd && ser_ptr == AW'(DEPTH-1)) |=> ser_ptr == '0);

    // R7
    half_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_mode && ser_step && !xfer_rd && (&ser_ptr[HW-1:0]))
        |=> (!split_mode || half_flag != $past(half_flag)));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_mode && !ser_step && !xfer_rd) |=> (!split_mode || $stable(half_flag)));

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> $past(split_req));

    // R10
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_req && !split_mode && !ser_step && !xfer_rd) |=> ($stable(ser_ptr) && xfer_err));

endmodule

bind split_serial_reg sar_chk #(.DEPTH(DEPTH)) u_sar_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .split_mode (split_mode),
    .ser_step   (ser_step),
    .xfer_rd    (xfer_rd),
    .split_req  (split_req),
    .half_flag  (half_flag),
    .xfer_err   (xfer_err),
    .ser_ptr    (ser_ptr),
    .tap_addr   (tap_addr)
);

// File: tb/split_serial_reg_tb.sv
// Bench for split_serial_reg: behavioural model compared every cycle.
module split_serial_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 512;
    localparam int WIDTH = 4;
    localparam int AW = 9;
    localparam int RW = DEPTH * WIDTH;
    localparam int HALF = DEPTH / 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             split_mode = 1'b0;
    logic             ser_dir = 1'b0;
    logic             ser_step = 1'b0;
    logic [WIDTH-1:0] ser_din = '0;
    logic [WIDTH-1:0] ser_dout;
    logic [AW-1:0]    ser_ptr;
    logic             half_flag;
    logic             xfer_rd = 1'b0;
    logic             xfer_wr = 1'b0;
    logic             split_req = 1'b0;
    logic             split_half = 1'b0;
    logic [AW-1:0]    tap_addr = '0;
    logic [RW-1:0]    row_rd_data = '0;
    logic [RW-1:0]    row_wr_data;
    logic             row_wr_en;
    logic             xfer_err;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // model state
    logic [WIDTH-1:0] m_mem [DEPTH];
    int m_ptr = 0;
    int m_off [2] = '{0, 0};
    bit m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_serial_reg #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .ser_dir(ser_dir),
        .ser_step(ser_step), .ser_din(ser_din), .ser_dout(ser_dout),
        .ser_ptr(ser_ptr), .half_flag(half_flag), .xfer_rd(xfer_rd),
        .xfer_wr(xfer_wr), .split_req(split_req), .split_half(split_half),
        .tap_addr(tap_addr), .row_rd_data(row_rd_data),
        .row_wr_data(row_wr_data), .row_wr_en(row_wr_en), .xfer_err(xfer_err)
    );

    function automatic logic [RW-1:0] mkrow(int seed);
        logic [RW-1:0] r;
        for (int i = 0; i < DEPTH; i++) r[i*WIDTH +: WIDTH] = 4'(i * seed + seed * 7 + (i >> 3));
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Compare ports against the model (called at a falling edge)
    task automatic compare();
        bit mflag;
        mflag = split_mode && (m_ptr >= HALF);
        chk(ser_ptr == AW'(m_ptr), cur_req, "ser_ptr", int'(ser_ptr), m_ptr);
        chk(half_flag == mflag, cur_req, "half_flag", int'(half_flag), int'(mflag));
        chk(ser_dout == m_mem[m_ptr], cur_req, "ser_dout", int'(ser_dout), int'(m_mem[m_ptr]));
        chk(xfer_err == m_err, cur_req, "xfer_err", int'(xfer_err), int'(m_err));
    endtask

    // One clock: check write-back, advance model, compare after the edge
    task automatic tick();
        bit ok;
        bit act_hi;
        int other;
        #1;
        if (xfer_wr) begin
            int first_bad;
            first_bad = -1;
            for (int i = 0; i < DEPTH; i++)
                if (first_bad < 0 && row_wr_data[i*WIDTH +: WIDTH] !== m_mem[i]) first_bad = i;
            // R3
            chk(row_wr_en == 1'b1, "R3", "row_wr_en", int'(row_wr_en), 1);
            if (first_bad < 0) chk(1'b1, "R3", "row_wr_data", 0, 0);
            else chk(1'b0, "R3", "row_wr_data entry", int'(row_wr_data[first_bad*WIDTH +: WIDTH]), int'(m_mem[first_bad]));
        end
        act_hi = (m_ptr >= HALF);
        ok = split_req && split_mode && (split_half != act_hi);
        m_err = split_req && !ok;
        if (ok) begin
            for (int i = 0; i < HALF; i++) begin
                int j;
                j = (split_half ? HALF : 0) + i;
                m_mem[j] = row_rd_data[j*WIDTH +: WIDTH];
            end
            m_off[split_half] = int'(tap_addr) % HALF;
        end
        if (xfer_rd) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = row_rd_data[i*WIDTH +: WIDTH];
            m_ptr = int'(tap_addr);
        end else if (ser_step) begin
            if (ser_dir) m_mem[m_ptr] = ser_din;
            if (split_mode && (m_ptr % HALF) == HALF - 1) begin
                other = act_hi ? 0 : 1;
                m_ptr = other * HALF + m_off[other];
            end else begin
                m_ptr = (m_ptr + 1) % DEPTH;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle_inputs();
        ser_step = 0; xfer_rd = 0; xfer_wr = 0; split_req = 0;
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) begin
            idle_inputs();
            ser_step = 1;
            ser_din = 4'(k * 3 + 1);
            tick();
        end
        idle_inputs();
    endtask

    task automatic full_load(int seed, int tap);
        idle_inputs();
        row_rd_data = mkrow(seed);
        tap_addr = AW'(tap);
        xfer_rd = 1;
        tick();
        idle_inputs();
    endtask

    task automatic half_load(int seed, bit h, int tap);
        idle_inputs();
        row_rd_data = mkrow(seed);
        tap_addr = AW'(tap);
        split_half = h;
        split_req = 1;
        tick();
        idle_inputs();
    endtask

    task automatic step_to(int target);
        while (m_ptr != target) steps(1);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [RW-1:0] rb;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        chk(ser_ptr == '0, "R1", "ser_ptr", int'(ser_ptr), 0);
        chk(half_flag == 1'b0, "R1", "half_flag", int'(half_flag), 0);
        chk(xfer_err == 1'b0, "R1", "xfer_err", int'(xfer_err), 0);
        chk(ser_dout == '0, "R1", "ser_dout", int'(ser_dout), 0);

        // R2 full load, single-ring mode
        cur_req = "R2";
        full_load(3, 5);
        rb = mkrow(3);
        chk(ser_ptr == 9'd5, "R2", "ptr after load", int'(ser_ptr), 5);
        chk(ser_dout == rb[5*WIDTH +: WIDTH], "R2", "dout after load", int'(ser_dout), int'(rb[5*WIDTH +: WIDTH]));

        // R4 output streaming, R5 wrap past 511
        cur_req = "R4";
        step_to(DEPTH - 1);
        cur_req = "R5";
        steps(1);
        chk(ser_ptr == '0, "R5", "wrap to 0", int'(ser_ptr), 0);
        chk(half_flag == 1'b0, "R5", "flag in ring mode", int'(half_flag), 0);
        steps(20);

        // R2 priority over a simultaneous strobe
        cur_req = "R2";
        idle_inputs();
        row_rd_data = mkrow(5);
        tap_addr = 9'd300;
        xfer_rd = 1;
        ser_step = 1;
        ser_dir = 1;
        ser_din = 4'hF;
        tick();
        idle_inputs();
        chk(ser_ptr == 9'd300, "R2", "load beats step", int'(ser_ptr), 300);

        // R4 input mode over the whole ring, R3 write-back
        cur_req = "R4";
        ser_dir = 1;
        steps(DEPTH);
        cur_req = "R3";
        idle_inputs();
        xfer_wr = 1;
        tick();
        idle_inputs();
        ser_dir = 0;

        // R10 half request in ring mode
        cur_req = "R10";
        half_load(9, 1, 4);
        chk(xfer_err == 1'b1, "R10", "err in ring mode", int'(xfer_err), 1);
        steps(1);
        chk(xfer_err == 1'b0, "R10", "err one cycle", int'(xfer_err), 0);

        // Split mode: R8 default entry, R6 flag
        split_mode = 1;
        cur_req = "R8";
        full_load(11, 254);
        steps(2);
        chk(ser_ptr == 9'd256, "R8", "default offset", int'(ser_ptr), 256);
        cur_req = "R6";
        chk(half_flag == 1'b1, "R6", "flag high half", int'(half_flag), 1);

        // R10 request aimed at the streamed half
        cur_req = "R10";
        half_load(13, 1, 40);
        chk(xfer_err == 1'b1, "R10", "err on active half", int'(xfer_err), 1);
        steps(1);
        chk(xfer_err == 1'b0, "R10", "err cleared", int'(xfer_err), 0);

        // R9 reload the idle low half; high half keeps its data
        cur_req = "R9";
        half_load(17, 0, 7);
        chk(xfer_err == 1'b0, "R9", "no err on idle half", int'(xfer_err), 0);
        step_to(300);
        rb = mkrow(11);
        chk(ser_dout == rb[300*WIDTH +: WIDTH], "R9", "streamed half intact", int'(ser_dout), int'(rb[300*WIDTH +: WIDTH]));

        // R7 cross back into the low half at its offset
        cur_req = "R7";
        step_to(DEPTH - 1);
        steps(1);
        rb = mkrow(17);
        chk(ser_ptr == 9'd7, "R7", "enter low at offset", int'(ser_ptr), 7);
        chk(half_flag == 1'b0, "R6", "flag low half", int'(half_flag), 0);
        chk(ser_dout == rb[7*WIDTH +: WIDTH], "R9", "reloaded low data", int'(ser_dout), int'(rb[7*WIDTH +: WIDTH]));

        // R7 half load in the same cycle as the crossing
        step_to(HALF - 1);
        idle_inputs();
        row_rd_data = mkrow(23);
        tap_addr = 9'd20;
        split_half = 1;
        split_req = 1;
        ser_step = 1;
        tick();
        idle_inputs();
        rb = mkrow(23);
        chk(ser_ptr == 9'd276, "R7", "same-cycle offset", int'(ser_ptr), 276);
        chk(ser_dout == rb[276*WIDTH +: WIDTH], "R9", "same-cycle data", int'(ser_dout), int'(rb[276*WIDTH +: WIDTH]));

        // R7 low offset persists across another lap
        step_to(DEPTH - 1);
        steps(1);
        chk(ser_ptr == 9'd7, "R7", "offset persists", int'(ser_ptr), 7);

        // R4 input mode in split mode, then R3 write-back
        cur_req = "R4";
        ser_dir = 1;
        steps(300);
        ser_dir = 0;
        cur_req = "R3";
        idle_inputs();
        xfer_wr = 1;
        tick();
        idle_inputs();
        steps(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule